// File: doc/BRIEF.md
# Cascadable Programmable Pulse Generator

This block produces a periodic pulse on a single output pin from two byte-wide down-counters. A mode field joins the two counters into one 16-bit counter. The upper counter holds bits 15:8 and the lower counter holds bits 7:0. Software sets up the block through a byte-wide register port. It writes the period and the duty value as byte pairs, chooses one of eight count-clock tick lines, and enables the pin. Once it sets the run bit, the counter counts down on each selected tick. When the count reaches 1 it reloads, and the pin rises when the count equals the duty value.

The control logic is a two-state machine. In IDLE the counter is held. The START transition (run bit of the low channel set while a 16-bit mode is selected) loads the period and duty buffers and enters RUN. In RUN, each selected tick either decrements the counter or takes the RELOAD transition (a self-loop) when the count is 1 or less. RELOAD copies the buffers again, drives the internal level low and raises the underflow flag. The STOP transition (run bit cleared or mode left) returns to IDLE and forces the level low. Each reload can raise an interrupt through the flag and its enable.

Top module: `ppg_cascade`

## Requirements
- R1: After reset every register reads 0, `pulse_o` is low and `irq_o` is low.
- R2: Register map (address: contents). 0: low control {mode[7:6], irq enable[5], flag[4], pin enable[3], clock select[2:0]}. 1: high control {0[7:6], irq enable[5], flag[4], pin enable[3], clock select[2:0]}. 2 and 3: period low and high byte. 4 and 5: duty low and high byte. 6: run bits {high[1], low[0]}. 7: inversion bits {high[1], low[0]}. All writes read back through `rd_data` except flags.
- R3: The counter runs only when the low run bit is 1 and mode bit 7 is 1. Modes 0b10 and 0b11 behave identically, and with modes 0b00/0b01 no reload occurs.
- R4: In RUN each selected tick decrements the 16-bit count. A tick at count 1 or less instead reloads it from the period bytes, so a period P of at least 2 lasts P ticks.
- R5: The internal level goes high on the tick where the decremented count equals the duty value in both bytes, and goes low at each reload. So the high time is the duty value D in ticks for 0 < D < P, and the output stays low for D = 0 or D ≥ P.
- R6: Period and duty buffers are copied into the working registers only at START and RELOAD. A write during a period changes only the following periods.
- R7: Only `tick_i[sel]`, with sel from low control bits 2:0, advances the counter. Pulses on other tick lines are ignored.
- R8: The low flag is set at each reload. Writing 0 to bit 4 clears it, and writing 1 leaves it unchanged; a reload in the same cycle wins. `irq_o` is flag AND irq enable.
- R9: `pulse_o` = pin enable AND (level XOR low inversion bit).
- R10: With pin enable 0 the pin is low. Clearing the run bit stops counting and forces the level low, so the pin shows the inversion bit.
- R11: The high channel's run bit and inversion bit have no effect in 16-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| tick_i | input | NTICK | One-hot count-clock tick lines |
| pulse_o | output | 1 | Pulse pin |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: two byte halves and eight tick lines. Periods above 255, such as 258 and 515, make the high-byte reload and the high-byte duty compare observable. Duty values that share a low byte with a wrong-high-byte count would expose a compare that checks only one half. Driving a tick on a line other than the selected one makes the clock-select path visible. Switching between modes 0b10 and 0b11 and selecting tick line 3 confirms that both mode encodings and a non-zero select work.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
    localparam int REG_AW = 3;
    localparam int REG_DW = 8;

    typedef enum logic [REG_AW-1:0] {
        A_CTL_LO = 3'd0,
        A_CTL_HI = 3'd1,
        A_PER_LO = 3'd2,
        A_PER_HI = 3'd3,
        A_DUT_LO = 3'd4,
        A_DUT_HI = 3'd5,
        A_RUN    = 3'd6,
        A_INV    = 3'd7
    } reg_addr_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ppg_state_e;
endpackage

// File: rtl/ppg_regs.sv
module ppg_regs
    import ppg_pkg::*;
#(
    parameter int HW = 8,
    parameter int NH = 2,
    localparam int CW = HW * NH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [REG_DW-1:0] rd_data,
    input  logic              reload_i,
    output logic [CW-1:0]     per_o,
    output logic [CW-1:0]     duty_o,
    output logic [1:0]        mode_o,
    output logic [2:0]        sel_o,
    output logic              oe_o,
    output logic              ie_o,
    output logic              flag_o,
    output logic              run_o,
    output logic              inv_o
);
    logic [HW-1:0] per_q  [NH];
    logic [HW-1:0] duty_q [NH];
    logic [7:0]    ctl_lo, ctl_hi;
    logic [1:0]    run_q, inv_q;

    generate
        for (genvar h = 0; h < NH; h++) begin : g_half
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    per_q[h]  <= '0;
                    duty_q[h] <= '0;
                end else if (wr_en) begin
                    if (wr_addr == REG_AW'(A_PER_LO + h)) per_q[h]  <= wr_data[HW-1:0];
                    if (wr_addr == REG_AW'(A_DUT_LO + h)) duty_q[h] <= wr_data[HW-1:0];
                end
            end
            assign per_o[h*HW +: HW]  = per_q[h];
            assign duty_o[h*HW +: HW] = duty_q[h];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_lo <= '0;
            ctl_hi <= '0;
            run_q  <= '0;
            inv_q  <= '0;
        end else begin
            if (wr_en) begin
                unique case (wr_addr)
                    A_CTL_LO: begin
                        ctl_lo <= {wr_data[7:5], ctl_lo[4] & wr_data[4], wr_data[3:0]};
                    end
                    A_CTL_HI: begin
                        ctl_hi <= {2'b00, wr_data[5], ctl_hi[4] & wr_data[4], wr_data[3:0]};
                    end
                    A_RUN:   run_q <= wr_data[1:0];
                    A_INV:   inv_q <= wr_data[1:0];
                    default: ;
                endcase
            end
            if (reload_i) ctl_lo[4] <= 1'b1;
        end
    end

    assign mode_o = ctl_lo[7:6];
    assign ie_o   = ctl_lo[5];
    assign flag_o = ctl_lo[4];
    assign oe_o   = ctl_lo[3];
    assign sel_o  = ctl_lo[2:0];
    assign run_o  = run_q[0];
    assign inv_o  = inv_q[0];

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTL_LO: rd_data = ctl_lo;
            A_CTL_HI: rd_data = ctl_hi;
            A_PER_LO: rd_data[HW-1:0] = per_q[0];
            A_PER_HI: rd_data[HW-1:0] = per_q[NH-1];
            A_DUT_LO: rd_data[HW-1:0] = duty_q[0];
            A_DUT_HI: rd_data[HW-1:0] = duty_q[NH-1];
            A_RUN:    rd_data[1:0] = run_q;
            A_INV:    rd_data[1:0] = inv_q;
            default:  rd_data = '0;
        endcase
    end

    a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> flag_o);
    a_r8_flag_no_self_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_i && !flag_o) |=> !flag_o);
endmodule

// File: rtl/ppg_core.sv
module ppg_core
    import ppg_pkg::*;
#(
    parameter int HW = 8,
    parameter int NH = 2,
    localparam int CW = HW * NH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic [CW-1:0] per_i,
    input  logic [CW-1:0] duty_i,
    output logic          reload_o,
    output logic          level_o
);
    ppg_state_e    state, state_nx;
    logic [CW-1:0] cnt, duty_w, cnt_dec;
    logic [NH-1:0] half_hit;
    logic          at_end;

    assign cnt_dec = cnt - CW'(1);
    assign at_end  = (cnt <= CW'(1));

    generate
        for (genvar h = 0; h < NH; h++) begin : g_cmp
            assign half_hit[h] = (cnt_dec[h*HW +: HW] == duty_w[h*HW +: HW]);
        end
    endgenerate

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (run_i) state_nx = ST_RUN;
            ST_RUN:  if (!run_i) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign reload_o = (state == ST_RUN) && run_i && tick_i && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            duty_w  <= '0;
            level_o <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    level_o <= 1'b0;
                    if (run_i) begin
                        cnt    <= per_i;
                        duty_w <= duty_i;
                    end
                end
                ST_RUN: begin
                    if (!run_i) begin
                        level_o <= 1'b0;
                    end else if (tick_i) begin
                        if (at_end) begin
                            cnt     <= per_i;
                            duty_w  <= duty_i;
                            level_o <= 1'b0;
                        end else begin
                            cnt <= cnt_dec;
                            if (&half_hit) level_o <= 1'b1;
                        end
                    end
                end
                default: level_o <= 1'b0;
            endcase
        end
    end

    a_r4_reload_loads_period: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |=> (cnt == $past(per_i)));
    a_r5_low_after_reload: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |=> !level_o);
    a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !tick_i) |=> $stable(cnt));
    a_r6_duty_kept_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !reload_o) |=> $stable(duty_w));
    a_r10_stop_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !level_o);
endmodule

// File: rtl/ppg_cascade.sv
module ppg_cascade
    import ppg_pkg::*;
#(
    parameter int HW    = 8,
    parameter int NH    = 2,
    parameter int NTICK = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [REG_DW-1:0] rd_data,
    input  logic [NTICK-1:0]  tick_i,
    output logic              pulse_o,
    output logic              irq_o
);
    localparam int CW = HW * NH;

    logic [CW-1:0] per, duty;
    logic [1:0]    mode;
    logic [2:0]    sel;
    logic          oe, ie, flag, run, inv, reload, level, tick, run_en;

    ppg_regs #(.HW(HW), .NH(NH)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .reload_i(reload),
        .per_o(per), .duty_o(duty), .mode_o(mode), .sel_o(sel),
        .oe_o(oe), .ie_o(ie), .flag_o(flag), .run_o(run), .inv_o(inv)
    );

    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NTICK; i++) begin
            if (sel == 3'(i)) tick = tick_i[i];
        end
    end

    assign run_en = run & mode[1];

    ppg_core #(.HW(HW), .NH(NH)) u_core (
        .clk(clk), .rst_n(rst_n),
        .run_i(run_en), .tick_i(tick),
        .per_i(per), .duty_i(duty),
        .reload_o(reload), .level_o(level)
    );

    assign pulse_o = oe & (level ^ inv);
    assign irq_o   = flag & ie;

    a_r3_no_reload_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !reload);
    a_r7_reload_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        reload |-> tick);
endmodule

// File: tb/sim_ppg_cascade.sv
module sim_ppg_cascade;
    import ppg_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [7:0] tick;
    logic       pulse, irq;
    logic       tick_on = 1'b0;
    int         tick_line = 0;
    int         errors = 0;
    int         checks = 0;
    logic [7:0] cur_ctrl = '0;

    always #2 clk = ~clk;
    assign tick = tick_on ? (8'd1 << tick_line) : 8'd0;

    ppg_cascade u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tick_i(tick), .pulse_o(pulse), .irq_o(irq)
    );

    typedef struct packed {
        logic [15:0] per;
        logic [15:0] duty;
        logic [1:0]  mode;
        logic [2:0]  sel;
        logic        inv;
        logic [15:0] exp_hi;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{16'd10,     16'd3,      2'b10, 3'd0, 1'b0, 16'd3},
        '{16'd10,     16'd0,      2'b10, 3'd0, 1'b0, 16'd0},
        '{16'd10,     16'd10,     2'b10, 3'd0, 1'b0, 16'd0},
        '{16'd10,     16'd12,     2'b10, 3'd0, 1'b0, 16'd0},
        '{16'h0102,   16'h0101,   2'b10, 3'd0, 1'b0, 16'd257},
        '{16'h0102,   16'h0002,   2'b10, 3'd0, 1'b0, 16'd2},
        '{16'd5,      16'd4,      2'b11, 3'd3, 1'b0, 16'd4},
        '{16'd7,      16'd2,      2'b10, 3'd0, 1'b1, 16'd5},
        '{16'h0203,   16'h0103,   2'b11, 3'd0, 1'b0, 16'd259}
    };

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic measure(output int n, output int hi);
        int guard;
        wr(A_CTL_LO, cur_ctrl);
        guard = 0;
        while (!irq && guard < 100000) begin
            @(negedge clk);
            guard++;
        end
        n = 0; hi = 0;
        wr_en = 1'b1; wr_addr = A_CTL_LO; wr_data = cur_ctrl;
        do begin
            if (pulse) hi++;
            n++;
            @(negedge clk);
            wr_en = 1'b0;
        end while (!irq && n < 100000);
    endtask

    task automatic setup(input vec_t v, input logic [1:0] runv, input logic [1:0] invv);
        wr(A_RUN, 8'd0);
        wr(A_PER_LO, v.per[7:0]);
        wr(A_PER_HI, v.per[15:8]);
        wr(A_DUT_LO, v.duty[7:0]);
        wr(A_DUT_HI, v.duty[15:8]);
        wr(A_INV, {6'd0, invv});
        cur_ctrl = {v.mode, 1'b1, 1'b0, 1'b1, v.sel};
        wr(A_CTL_LO, cur_ctrl);
        tick_line = int'(v.sel);
        wr(A_RUN, {6'd0, runv});
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n, hi, bad;
        logic [7:0] d;
        vec_t v;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(int'(pulse), 0, "R1 pulse");
        check(int'(irq), 0, "R1 irq");
        bad = 0;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            if (d != 8'd0) bad++;
        end
        check(bad, 0, "R1 regs zero");
        rst_n = 1'b1;
        @(negedge clk);
        tick_on = 1'b1;

        // R2: register readback
        wr(A_PER_HI, 8'hA5);
        rd(A_PER_HI, d);
        check(int'(d), 8'hA5, "R2 period high byte");
        wr(A_CTL_HI, 8'hFF);
        rd(A_CTL_HI, d);
        check(int'(d), 8'h2F, "R2 high control layout");
        wr(A_CTL_HI, 8'h00);

        // R4 R5 R3 R7 R9: vector table
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            setup(v, 2'b01, {1'b0, v.inv});
            measure(n, hi);
            check(n, int'(v.per), $sformatf("R4 period vec%0d", i));
            check(hi, int'(v.exp_hi), $sformatf("R5 R9 high time vec%0d", i));
        end

        // R6: buffer writes take effect at next boundary
        v = VEC[0];
        setup(v, 2'b01, 2'b00);
        measure(n, hi);
        wr(A_CTL_LO, cur_ctrl);
        wr(A_PER_LO, 8'd20);
        wr(A_DUT_LO, 8'd6);
        n = 0; hi = 0;
        while (!irq && n < 1000) begin
            if (pulse) hi++;
            n++;
            @(negedge clk);
        end
        check(n, 7, "R6 current period length kept");
        check(hi, 3, "R6 current duty kept");
        measure(n, hi);
        check(n, 20, "R6 new period");
        check(hi, 6, "R6 new duty");

        // R7: tick on a non-selected line is ignored
        wr(A_CTL_LO, cur_ctrl);
        tick_line = 5;
        d = {7'd0, pulse};
        bad = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (irq || pulse != d[0]) bad++;
        end
        check(bad, 0, "R7 other tick line ignored");
        tick_line = 0;

        // R8: flag behaviour and interrupt enable
        measure(n, hi);
        wr(A_CTL_LO, cur_ctrl & 8'hDF);
        repeat (25) @(negedge clk);
        rd(A_CTL_LO, d);
        check(int'(d[4]), 1, "R8 flag set by reload");
        check(int'(irq), 0, "R8 irq masked");
        wr(A_RUN, 8'd0);
        wr(A_CTL_LO, cur_ctrl & 8'hCF);
        rd(A_CTL_LO, d);
        check(int'(d[4]), 0, "R8 write 0 clears flag");
        wr(A_CTL_LO, (cur_ctrl & 8'hDF) | 8'h10);
        rd(A_CTL_LO, d);
        check(int'(d[4]), 0, "R8 write 1 no effect");

        // R10: stop forces inactive level, pin enable gates
        v = VEC[7];
        setup(v, 2'b01, 2'b01);
        repeat (12) @(negedge clk);
        wr(A_RUN, 8'd0);
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (pulse !== 1'b1) bad++;
        end
        check(bad, 0, "R10 stopped pin shows inversion");
        wr(A_CTL_LO, cur_ctrl & 8'hF7);
        wr(A_RUN, 8'd1);
        bad = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (pulse) bad++;
        end
        check(bad, 0, "R10 pin enable off holds low");

        // R3: mode 00 does not count
        v = VEC[0];
        v.mode = 2'b00;
        setup(v, 2'b01, 2'b00);
        wr(A_CTL_LO, cur_ctrl);
        bad = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (irq) bad++;
        end
        check(bad, 0, "R3 mode 00 no reload");

        // R11: high channel run and inversion bits have no effect
        v = VEC[0];
        setup(v, 2'b10, 2'b10);
        wr(A_CTL_LO, cur_ctrl);
        bad = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (irq || pulse) bad++;
        end
        check(bad, 0, "R11 high run bit alone idle");
        wr(A_RUN, 8'd3);
        measure(n, hi);
        check(n, 10, "R11 period with high bits set");
        check(hi, 3, "R11 no inversion from high bit");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule